// File: doc/BRIEF.md
# Signed least common multiple calculator

This block finds the least common multiple of two signed 8-bit operands in two's complement. An operator sets a switch bank and presses a load button, once for each operand. The first press after a computation starts writes operand A, the second writes operand B, and the pointer keeps alternating after that. A start button then runs the computation. When it finishes, the unsigned result and a ready flag drive the LEDs. Both operands stay stored, so pressing start again repeats the same computation.

Inside there is one control state machine that steers a small datapath. The datapath holds two working registers, a saved-quotient register, an accumulator and an up/down counter. The machine first replaces each operand with its magnitude, so -128 becomes 128 in a 9-bit register. It then finds the greatest common divisor with Euclid's method. Each remainder in that method comes from a normalise / subtract / restore sequence. The first magnitude is divided by the divisor with restoring shift-subtract steps. The quotient is then multiplied by the second magnitude with shift-add steps. No hardware divider or multiplier is used.

Top module: `lcm_signed8`

## Requirements
- R1: After reset, `ready` is 0 and `result` is 0.
- R2: While idle or done, each `load_btn` pulse stores `sw`, alternately into operand A and then operand B, starting with A. A `start_btn` pulse returns the pointer to A.
- R3: For two nonzero operands, `result` equals lcm(|A|, |B|) as an unsigned number.
- R4: If either operand is zero, `result` is 0 when `ready` rises.
- R5: An operand of -128 is treated as magnitude 128.
- R6: `ready` is 0 in the cycle after an accepted start. Once `ready` rises, it stays at 1 and `result` stays unchanged until the next start pulse.
- R7: `load_btn` and `start_btn` pulses that arrive while a computation is running have no effect.
- R8: `result` never exceeds 16256, so the upper bit of the 16-bit output is always 0.
- R9: A start with no new loads recomputes from the operands already stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sw | input | 8 | Operand value from the switches, two's complement |
| load_btn | input | 1 | Single-cycle pulse that stores `sw` into the selected operand |
| start_btn | input | 1 | Single-cycle pulse that starts a computation |
| result | output | 16 | Unsigned least common multiple |
| ready | output | 1 | High when `result` is valid |

## Verification
The hardest situations to reach from the ports are the long Euclid chains, where the remainder loop runs many times and the divisor must return exactly to its value before normalisation. Near-zero remainders are similar. The bench reaches them by sweeping every pair drawn from a set of values that includes -128, ±127, 126, 97 and -101, neighbouring primes and powers of two, in both orders. The same sweep also covers the zero and most-negative cases. Button pulses sent during a busy run are checked by repeating the run with no new loads, which shows that the stored operands and the pointer were not changed.

// File: rtl/lcm_signed8.sv
module lcm_signed8 #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   sw,
  input  logic           load_btn,
  input  logic           start_btn,
  output logic [2*W-1:0] result,
  output logic           ready
);
  localparam int MW = W + 1;
  localparam int RW = W + 2;
  localparam int PW = 2 * W + 2;
  localparam int CW = $clog2(W + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(MW);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_NORM, S_SUB, S_FIX, S_SWAP, S_DIV, S_MUL, S_DONE
  } state_t;

  state_t        st;
  logic          sel;
  logic [W-1:0]  opa, opb;
  logic [MW-1:0] ma, mb, rg2, rg3;
  logic [RW-1:0] rg1;
  logic [PW-1:0] acc;
  logic [CW-1:0] cnt;

  logic [MW-1:0] abs_a, abs_b;
  logic [RW-1:0] div_shift, div_diff;
  logic          div_fits, idle_like;

  assign abs_a = opa[W-1] ? (~{opa[W-1], opa} + 1'b1) : {1'b0, opa};
  assign abs_b = opb[W-1] ? (~{opb[W-1], opb} + 1'b1) : {1'b0, opb};

  assign div_shift = {rg1[W:0], rg3[W]};
  assign div_diff  = div_shift - {1'b0, rg2};
  assign div_fits  = div_shift >= {1'b0, rg2};

  assign idle_like = (st == S_IDLE) || (st == S_DONE);
  assign ready     = (st == S_DONE);
  assign result    = acc[2*W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      sel <= 1'b0;
      opa <= '0;
      opb <= '0;
      ma  <= '0;
      mb  <= '0;
      rg1 <= '0;
      rg2 <= '0;
      rg3 <= '0;
      acc <= '0;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: begin
          if (start_btn) begin
            sel <= 1'b0;
            ma  <= abs_a;
            mb  <= abs_b;
            rg1 <= {1'b0, abs_a};
            rg2 <= abs_b;
            cnt <= '0;
            st  <= S_CHK;
          end else if (load_btn) begin
            if (sel) opb <= sw;
            else     opa <= sw;
            sel <= ~sel;
          end
        end
        S_CHK: begin
          if (ma == '0 || mb == '0) begin
            acc <= '0;
            st  <= S_DONE;
          end else begin
            st <= S_NORM;
          end
        end
        S_NORM: begin
          if (!rg2[W]) begin
            rg2 <= {rg2[W-1:0], 1'b0};
            cnt <= cnt + 1'b1;
          end else begin
            st <= S_SUB;
          end
        end
        S_SUB: begin
          rg1 <= rg1 - {1'b0, rg2};
          st  <= S_FIX;
        end
        S_FIX: begin
          if (rg1[RW-1]) rg1 <= rg1 + {1'b0, rg2};
          if (cnt == '0) begin
            st <= S_SWAP;
          end else begin
            rg2 <= {1'b0, rg2[W:1]};
            cnt <= cnt - 1'b1;
            st  <= S_SUB;
          end
        end
        S_SWAP: begin
          if (rg1 == '0) begin
            rg3 <= ma;
            cnt <= CNT_FULL;
            st  <= S_DIV;
          end else begin
            rg1 <= {1'b0, rg2};
            rg2 <= rg1[W:0];
            st  <= S_NORM;
          end
        end
        S_DIV: begin
          if (div_fits) begin
            rg1 <= div_diff;
            rg3 <= {rg3[W-1:0], 1'b1};
          end else begin
            rg1 <= div_shift;
            rg3 <= {rg3[W-1:0], 1'b0};
          end
          cnt <= cnt - 1'b1;
          if (cnt == CNT_ONE) begin
            acc <= '0;
            cnt <= CNT_FULL;
            st  <= S_MUL;
          end
        end
        S_MUL: begin
          acc <= {acc[PW-2:0], 1'b0} + (rg3[W] ? {{(PW-MW){1'b0}}, mb} : '0);
          rg3 <= {rg3[W-1:0], 1'b0};
          cnt <= cnt - 1'b1;
          if (cnt == CNT_ONE) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_ready_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start_btn) |=> (ready && $stable(result)));

  assert_ready_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && start_btn) |=> !ready);

  assert_zero_short_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHK && (ma == '0 || mb == '0)) |=> (ready && result == '0));

  assert_rem_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SWAP) |-> (!rg1[RW-1] && rg1 < {1'b0, rg2}));

  assert_norm_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_NORM) |-> (rg2 != '0 && cnt <= CNT_FULL));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (acc[PW-1:2*W-1] == '0));

  assert_busy_ops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_like |=> ($stable(opa) && $stable(opb) && $stable(sel)));
endmodule

// File: tb/lcm_signed8_tb.sv
module lcm_signed8_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sw = '0;
  logic        load_btn = 1'b0;
  logic        start_btn = 1'b0;
  logic [15:0] result;
  logic        ready;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  lcm_signed8 u_dut (
    .clk(clk), .rst_n(rst_n), .sw(sw), .load_btn(load_btn),
    .start_btn(start_btn), .result(result), .ready(ready)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected below 190000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic int lcm_ref(int a, int b);
    int x, y, t, ma, mb;
    ma = (a < 0) ? -a : a;
    mb = (b < 0) ? -b : b;
    if (ma == 0 || mb == 0) return 0;
    x = ma; y = mb;
    while (y != 0) begin
      t = x % y; x = y; y = t;
    end
    return (ma / x) * mb;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load(int v);
    @(negedge clk);
    sw = 8'(v);
    load_btn = 1'b1;
    @(negedge clk);
    load_btn = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_btn = 1'b1;
    @(negedge clk);
    start_btn = 1'b0;
    check("R6 ready low after start", int'(ready), 0);
  endtask

  task automatic wait_ready();
    int n;
    n = 0;
    while (!ready && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!ready) check("R6 ready timeout", 0, 1);
  endtask

  task automatic run_pair(int a, int b);
    string tag;
    load(a);
    load(b);
    pulse_start();
    wait_ready();
    if (a == -128 || b == -128) tag = "R5 most-negative";
    else if (a == 0 || b == 0)  tag = "R4 zero operand";
    else                        tag = "R3 lcm";
    check(tag, int'(result), lcm_ref(a, b));
    if (result > 16'd16256) check("R8 range", int'(result), 16256);
  endtask

  int vals [20] = '{0, 1, -1, 2, -2, 3, 7, -12, 18, -36,
                    64, -64, 97, -101, 120, 127, -127, -128, 126, -90};

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ready", int'(ready), 0);
    check("R1 reset result", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_pair(6, 4);
    pulse_start();
    wait_ready();
    check("R9 rerun stored operands", int'(result), 12);

    load(5);
    pulse_start();
    wait_ready();
    check("R2 pointer back to A", int'(result), 20);

    load(3); load(5); load(7);
    pulse_start();
    wait_ready();
    check("R2 third load goes to A", int'(result), 35);

    repeat (4) @(negedge clk);
    check("R6 result held", int'(result), 35);
    check("R6 ready held", int'(ready), 1);

    load(-128); load(127);
    pulse_start();
    repeat (3) @(negedge clk);
    sw = 8'd9; load_btn = 1'b1; start_btn = 1'b1;
    @(negedge clk);
    load_btn = 1'b0; start_btn = 1'b0;
    wait_ready();
    check("R7 busy pulses ignored", int'(result), 16256);
    check("R8 max value top bit", int'(result[15]), 0);
    pulse_start();
    wait_ready();
    check("R7 operands kept through busy load", int'(result), 16256);

    foreach (vals[i])
      foreach (vals[j])
        run_pair(vals[i], vals[j]);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule